// File: doc/BRIEF.md
# Operand Normaliser for a Circular-Core Processor

This block prepares the two operands of a fetched instruction before the instruction's operation runs. Each operand carries a two-bit addressing mode and a field value. The block turns the operand into one of two things: immediate data, or an absolute address in a circular core of `CORE_SIZE` words. It handles one operand at a time. The A operand is finished completely before work on the B operand begins.

A controller presents the instruction's modes, the two fields and the program counter, then pulses `start`. The indirect modes read the B-field of a core word through a single-port memory interface. The predecrement mode also writes a decremented value back into that same word. The block issues at most one memory access per clock. When both operands are resolved, it pulses `done` for one cycle. The resolved values and their immediate flags then remain on the outputs until the next instruction is resolved.

The memory answers a read on the cycle after the request. Every word of the core is expected to start out with a B-field of zero, which is the empty halt word. All address arithmetic wraps at `CORE_SIZE`.

Top module: `opnd_normaliser`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_req`, `mem_we`, both operand values and both immediate flags are 0.
- R2: A `start` pulse seen while idle raises `busy` from the next cycle. `busy` stays high until `done` pulses. `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R3: Mode 0 (immediate) returns the field value itself with the immediate flag set, and makes no memory access.
- R4: Mode 1 (direct) returns (pc + field) mod `CORE_SIZE` with the immediate flag clear, and makes no memory access.
- R5: Mode 2 (indirect) reads the B-field d at p = (pc + field) mod `CORE_SIZE` and returns (p + d) mod `CORE_SIZE`. It does not write memory.
- R6: Mode 3 (predecrement) reads d at p, writes e = (d − 1) mod `CORE_SIZE` back to p on the very next cycle (so 0 becomes `CORE_SIZE` − 1), and returns (p + e) mod `CORE_SIZE`.
- R7: The A operand is fully resolved, including its write-back, before B issues any access. A predecrement by A on the word that B reads is therefore seen by B.
- R8: `done` rises exactly 2 + k clock edges after the edge that accepted `start`, where k is the number of operands in mode 2 or 3. There is never more than one memory access per cycle.
- R9: A `start` pulse while `busy` is high is ignored: the outputs are those of the instruction already in progress, and only one `done` pulse follows.
- R10: A read is `mem_req` high with `mem_we` low, and its data is taken from `mem_rdata` one cycle later. A write is `mem_req` and `mem_we` both high. Every address issued is below `CORE_SIZE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin normalising the presented instruction |
| mode_a | input | 2 | A addressing mode: 0 immediate, 1 direct, 2 indirect, 3 predecrement |
| mode_b | input | 2 | B addressing mode, same encoding |
| field_a | input | AW | A field value, below CORE_SIZE |
| field_b | input | AW | B field value, below CORE_SIZE |
| pc | input | AW | Address of the instruction, below CORE_SIZE |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle pulse: both operands resolved |
| opa_val | output | AW | Resolved A operand |
| opa_imm | output | 1 | A operand is immediate data |
| opb_val | output | AW | Resolved B operand |
| opb_imm | output | 1 | B operand is immediate data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write of the B-field |
| mem_addr | output | AW | Core address of the access |
| mem_wdata | output | AW | Decremented B-field to store |
| mem_rdata | input | AW | B-field read, valid one cycle after a read |

## Verification
The hardest case to reach from the ports is an A predecrement that changes the very word B then reads. In that case B's result is correct only if the write-back lands before B's read is issued. The stimulus sets up this aliasing deliberately: some vectors use equal fields in modes 3/2 and 3/3, and one uses a pointer word whose B-field is zero, so the decrement also has to wrap. After every vector, a bench reference model that applies the updates in A-then-B order is compared against the whole core image, not just the two operand values.

// File: rtl/opn_pkg.sv
package opn_pkg;

    typedef enum logic [1:0] {
        AM_IMM = 2'd0,
        AM_DIR = 2'd1,
        AM_IND = 2'd2,
        AM_PRE = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_RDATA = 2'd2
    } nst_e;

endpackage

// File: rtl/opn_mod_add.sv
// Modular adder: both inputs must already lie in [0, MOD).
module opn_mod_add #(
    parameter int MOD = 1000,
    parameter int AW  = $clog2(MOD)
) (
    input  logic [AW-1:0] x,
    input  logic [AW-1:0] y,
    output logic [AW-1:0] s
);
    localparam logic [AW:0] MODV = (AW+1)'(MOD);

    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, x} + {1'b0, y};
        if (sum >= MODV) begin
            s = AW'(sum - MODV);
        end else begin
            s = AW'(sum);
        end
    end
endmodule

// File: rtl/opn_side_sel.sv
// Picks the mode and field of the operand currently being resolved.
module opn_side_sel #(
    parameter int AW = 10
) (
    input  logic                side_b,
    input  opn_pkg::amode_e     mode_a,
    input  opn_pkg::amode_e     mode_b,
    input  logic [AW-1:0]       field_a,
    input  logic [AW-1:0]       field_b,
    output opn_pkg::amode_e     cur_mode,
    output logic [AW-1:0]       cur_field
);
    always_comb begin
        cur_mode  = side_b ? mode_b  : mode_a;
        cur_field = side_b ? field_b : field_a;
    end
endmodule

// File: rtl/opnd_normaliser.sv
module opnd_normaliser #(
    parameter int CORE_SIZE = 1000,
    parameter int AW        = $clog2(CORE_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode_a,
    input  logic [1:0]    mode_b,
    input  logic [AW-1:0] field_a,
    input  logic [AW-1:0] field_b,
    input  logic [AW-1:0] pc,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] opa_val,
    output logic          opa_imm,
    output logic [AW-1:0] opb_val,
    output logic          opb_imm,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic [AW-1:0] mem_rdata
);
    import opn_pkg::*;

    localparam logic [AW-1:0] MINUS_ONE = AW'(CORE_SIZE - 1);

    typedef struct packed {
        nst_e          st;
        logic          side_b;
        amode_e        ma;
        amode_e        mb;
        logic [AW-1:0] fa;
        logic [AW-1:0] fb;
        logic [AW-1:0] pc;
        logic [AW-1:0] ptr;
        logic [AW-1:0] av;
        logic          ai;
        logic [AW-1:0] bv;
        logic          bi;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;

    amode_e        cur_mode;
    logic [AW-1:0] cur_field;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] offset;
    logic [AW-1:0] ind_addr;
    logic          res_rdy;
    logic [AW-1:0] res_val;
    logic          res_imm;

    opn_side_sel #(.AW(AW)) u_sel (
        .side_b    (r_q.side_b),
        .mode_a    (r_q.ma),
        .mode_b    (r_q.mb),
        .field_a   (r_q.fa),
        .field_b   (r_q.fb),
        .cur_mode  (cur_mode),
        .cur_field (cur_field)
    );

    // pc + field
    opn_mod_add #(.MOD(CORE_SIZE), .AW(AW)) u_add_base (
        .x (r_q.pc), .y (cur_field), .s (eff_addr)
    );

    // read value - 1, done as + (M-1)
    opn_mod_add #(.MOD(CORE_SIZE), .AW(AW)) u_add_dec (
        .x (mem_rdata), .y (MINUS_ONE), .s (dec_val)
    );

    assign offset = (cur_mode == AM_PRE) ? dec_val : mem_rdata;

    // pointer word address + offset
    opn_mod_add #(.MOD(CORE_SIZE), .AW(AW)) u_add_ind (
        .x (r_q.ptr), .y (offset), .s (ind_addr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        res_rdy   = 1'b0;
        res_val   = '0;
        res_imm   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = eff_addr;
        mem_wdata = dec_val;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_EVAL;
                    r_d.side_b = 1'b0;
                    r_d.ma     = amode_e'(mode_a);
                    r_d.mb     = amode_e'(mode_b);
                    r_d.fa     = field_a;
                    r_d.fb     = field_b;
                    r_d.pc     = pc;
                end
            end
            ST_EVAL: begin
                case (cur_mode)
                    AM_IMM: begin
                        res_rdy = 1'b1;
                        res_val = cur_field;
                        res_imm = 1'b1;
                    end
                    AM_DIR: begin
                        res_rdy = 1'b1;
                        res_val = eff_addr;
                    end
                    default: begin
                        mem_req = 1'b1;
                        r_d.ptr = eff_addr;
                        r_d.st  = ST_RDATA;
                    end
                endcase
            end
            ST_RDATA: begin
                res_rdy = 1'b1;
                res_val = ind_addr;
                if (cur_mode == AM_PRE) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = r_q.ptr;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (res_rdy) begin
            if (!r_q.side_b) begin
                r_d.av     = res_val;
                r_d.ai     = res_imm;
                r_d.side_b = 1'b1;
                r_d.st     = ST_EVAL;
            end else begin
                r_d.bv   = res_val;
                r_d.bi   = res_imm;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign opa_val = r_q.av;
    assign opa_imm = r_q.ai;
    assign opb_val = r_q.bv;
    assign opb_imm = r_q.bi;

endmodule

// File: rtl/opnd_normaliser_chk.sv
module opnd_normaliser_chk #(
    parameter int CORE_SIZE = 1000,
    parameter int AW        = $clog2(CORE_SIZE)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] opa_val,
    input logic          opa_imm,
    input logic [AW-1:0] opb_val,
    input logic          opb_imm,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic [AW-1:0] mem_rdata
);
    localparam logic [AW-1:0] TOP = AW'(CORE_SIZE - 1);

    // R2: done lasts a single cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done coincides with return to idle
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: an accepted start makes the block busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: a write-back follows a read of the same word on the next cycle
    a_r6_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req) && !$past(mem_we)
                                 && mem_addr == $past(mem_addr)));

    // R6: stored value is the read value minus one, wrapping at zero
    a_r6_wdata_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            (mem_wdata == ((mem_rdata == '0) ? TOP : mem_rdata - 1'b1)));

    // R10: the memory is quiet while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10: addresses stay inside the core
    a_r10_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr <= TOP));

    // R4: resolved addresses stay inside the core
    a_r4_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((opa_imm || opa_val <= TOP) && (opb_imm || opb_val <= TOP)));

endmodule

bind opnd_normaliser opnd_normaliser_chk #(.CORE_SIZE(CORE_SIZE), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .opa_val   (opa_val),
    .opa_imm   (opa_imm),
    .opb_val   (opb_val),
    .opb_imm   (opb_imm),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/sim_opnd_normaliser.sv
`timescale 1ns/1ps
module sim_opnd_normaliser;
    localparam int M  = 1000;
    localparam int AW = $clog2(M);

    typedef struct packed {
        logic [1:0]    ma;
        logic [1:0]    mb;
        logic [AW-1:0] fa;
        logic [AW-1:0] fb;
        logic [AW-1:0] pc;
        logic [3:0]    lat;
    } vec_t;

    // modes, fields, pc, expected latency in edges (2 + indirect-type operands)
    localparam vec_t VECS [11] = '{
        '{2'd0, 2'd0, 10'd7,   10'd999, 10'd5,   4'd2},  // R3 immediate pair
        '{2'd1, 2'd1, 10'd3,   10'd998, 10'd10,  4'd2},  // R4 direct, B wraps
        '{2'd1, 2'd0, 10'd15,  10'd4,   10'd990, 4'd2},  // R4 A wraps past top
        '{2'd2, 2'd1, 10'd20,  10'd1,   10'd40,  4'd3},  // R5 indirect A
        '{2'd2, 2'd2, 10'd0,   10'd6,   10'd200, 4'd4},  // R5 both indirect
        '{2'd3, 2'd0, 10'd3,   10'd0,   10'd700, 4'd3},  // R6 decrement of zero
        '{2'd3, 2'd2, 10'd5,   10'd5,   10'd100, 4'd4},  // R7 A predec seen by B
        '{2'd3, 2'd3, 10'd1,   10'd1,   10'd300, 4'd4},  // R7 double predec
        '{2'd0, 2'd3, 10'd12,  10'd2,   10'd450, 4'd3},  // R6 predec on B
        '{2'd2, 2'd3, 10'd999, 10'd0,   10'd0,   4'd4},  // R5 pointer at top
        '{2'd3, 2'd1, 10'd0,   10'd997, 10'd600, 4'd3}   // R6 predec on own word
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode_a = '0, mode_b = '0;
    logic [AW-1:0] field_a = '0, field_b = '0, pc = '0;
    logic          busy, done, opa_imm, opb_imm, mem_req, mem_we;
    logic [AW-1:0] opa_val, opb_val, mem_addr, mem_wdata;
    logic [AW-1:0] mem_rdata;

    logic [AW-1:0] core    [M];
    logic [AW-1:0] ref_mem [M];
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    opnd_normaliser #(.CORE_SIZE(M)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mode_a(mode_a), .mode_b(mode_b), .field_a(field_a), .field_b(field_b),
        .pc(pc), .busy(busy), .done(done),
        .opa_val(opa_val), .opa_imm(opa_imm), .opb_val(opb_val), .opb_imm(opb_imm),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [AW-1:0] preload(int i);
        return (i < 500) ? AW'((i * 37 + 11) % M) : '0;
    endfunction

    // Core model: B-fields only, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < M; i++) core[i] <= preload(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) begin
                core[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= core[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (rst_n && done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference resolution of one operand; updates ref_mem in order
    task automatic ref_resolve(input logic [1:0] m, input int f, input int p,
                               output int v, output bit imm);
        int a, d;
        imm = (m == 2'd0);
        if (m == 2'd0) begin
            v = f;
        end else begin
            a = (p + f) % M;
            if (m == 2'd1) begin
                v = a;
            end else begin
                d = int'(ref_mem[a]);
                if (m == 2'd3) begin
                    d = (d + M - 1) % M;
                    ref_mem[a] = AW'(d);
                end
                v = (a + d) % M;
            end
        end
    endtask

    task automatic run_one(input vec_t v, input int idx);
        int ea, eb, cyc, r0, w0, mism, nind, npre;
        bit ia, ib;
        ref_resolve(v.ma, int'(v.fa), int'(v.pc), ea, ia);
        ref_resolve(v.mb, int'(v.fb), int'(v.pc), eb, ib);
        nind = int'(v.ma >= 2'd2) + int'(v.mb >= 2'd2);
        npre = int'(v.ma == 2'd3) + int'(v.mb == 2'd3);
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        mode_a = v.ma; mode_b = v.mb; field_a = v.fa; field_b = v.fb; pc = v.pc;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc - 1 == int'(v.lat), $sformatf("R8 latency vec%0d", idx), cyc - 1, int'(v.lat));
        chk(int'(opa_val) == ea, $sformatf("R7 A value vec%0d", idx), int'(opa_val), ea);
        chk(opa_imm == ia, $sformatf("R3 A imm flag vec%0d", idx), int'(opa_imm), int'(ia));
        chk(int'(opb_val) == eb, $sformatf("R7 B value vec%0d", idx), int'(opb_val), eb);
        chk(opb_imm == ib, $sformatf("R3 B imm flag vec%0d", idx), int'(opb_imm), int'(ib));
        @(negedge clk);
        chk(!done, $sformatf("R2 done pulse vec%0d", idx), int'(done), 0);
        chk(rd_cnt - r0 == nind, $sformatf("R5 read count vec%0d", idx), rd_cnt - r0, nind);
        chk(wr_cnt - w0 == npre, $sformatf("R6 write count vec%0d", idx), wr_cnt - w0, npre);
        mism = 0;
        for (int i = 0; i < M; i++) if (core[i] !== ref_mem[i]) mism++;
        chk(mism == 0, $sformatf("R6 core image vec%0d", idx), mism, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ea, eb, d0;
        bit ia, ib;
        for (int i = 0; i < M; i++) ref_mem[i] = preload(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req && !mem_we, "R1 reset controls",
            int'({busy, done, mem_req, mem_we}), 0);
        chk(opa_val == '0 && opb_val == '0 && !opa_imm && !opb_imm, "R1 reset operands",
            int'(opa_val) + int'(opb_val), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 idle after release", int'(busy), 0);

        for (int k = 0; k < 11; k++) run_one(VECS[k], k);

        // R9: start while busy is ignored
        ref_resolve(2'd2, 1, 50, ea, ia);
        ref_resolve(2'd2, 2, 50, eb, ib);
        d0 = done_cnt;
        @(negedge clk);
        mode_a = 2'd2; mode_b = 2'd2; field_a = 10'd1; field_b = 10'd2; pc = 10'd50;
        start = 1'b1;
        @(negedge clk);
        chk(busy, "R2 busy after start", int'(busy), 1);
        mode_a = 2'd3; mode_b = 2'd3; field_a = 10'd3; field_b = 10'd3; pc = 10'd7;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);
        chk(int'(opa_val) == ea, "R9 A kept", int'(opa_val), ea);
        chk(int'(opb_val) == eb, "R9 B kept", int'(opb_val), eb);
        chk(!busy, "R2 idle after done", int'(busy), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule